// File: doc/BRIEF.md
# Functional Unit Supply Gate Controller

This block sits beside an issue-parallel data path with three execution units (arithmetic/logic, address/load-store, multiply-accumulate). Each instruction slot carries one supply bit that software scheduling sets. The bit is cleared only inside a stall run long enough to justify turning a unit's power off. For every unit the controller keeps a two-deep history of these bits, with one flop at the fetch stage and one at the execute stage. The history advances whenever the pipeline advances. The unit's supply enable drops only when both history flops hold zero.

Because the fetch-stage flop alone can set the enable again, a unit is woken as soon as a useful instruction is fetched for it. The wake-up therefore comes one stage before that instruction's operands reach the unit, which gives the unit time to recharge. While a unit is unpowered, its result bus is clamped to zero so that no undefined value propagates. The clamp lifts only after the supply has been back on for one full clock cycle.

Top module: `fu_supply_ctrl`

## Requirements
- R1: While reset is low at a clock edge, both history flops of every unit are set to 1. After reset every supply enable is 1 and every unit output passes through unchanged.
- R2: At a clock edge with `adv` high, each unit's fetch-stage flop takes that unit's bit of `sup_bit` (bit 0 arithmetic, bit 1 load-store, bit 2 multiply-accumulate). The execute-stage flop takes the old fetch-stage value.
- R3: `sup_en` of a unit is 0 exactly when the last two bits captured for that unit were both 0. A single captured 0 leaves it at 1.
- R4: At a clock edge with `adv` low, the history is held and no `sup_en` bit changes, whatever `sup_bit` is.
- R5: A 1 captured for a unit sets its `sup_en` at that same edge, one stage ahead of the execute-stage flop.
- R6: While a unit's `sup_en` is 0, its slice of `unit_out` is all zeros.
- R7: In the first cycle after a unit's `sup_en` returns to 1, its slice of `unit_out` is still zero.
- R8: Each unit's enable and clamp depend only on that unit's own supply bits.
- R9: When `sup_en` of a unit has been 1 at the previous edge and is still 1, its `unit_out` slice equals its `raw_in` slice. Slice u is bits [16u+15:16u].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| adv | input | 1 | Pipeline stage advance |
| sup_bit | input | 3 | Supply bit of the instruction fetched for each unit |
| raw_in | input | 48 | Result buses straight from the three units |
| sup_en | output | 3 | Supply enable per unit, 1 = powered |
| unit_out | output | 48 | Result buses after the isolation clamp |

## Verification
The main function is tried with stall runs of length one, two and longer on one unit while another unit stays busy. A run of one tells the two-deep rule apart from a single-flop rule. Longer runs show that the enable falls only after the second zero. The bench also holds `adv` low over a pending one-bit, which separates capture on advance from capture on every clock. The wake-up cycle compares clamped and released output with a nonzero raw bus. A long random stream of bits, stalls and data is then compared on every clock against a queue-based behavioural model.

// File: rtl/fu_pwr_pkg.sv
// Shared types and constants for the functional-unit supply controller.
// Assumes one supply bit per unit per fetched instruction.
package fu_pwr_pkg;
    // Two-deep supply history of one unit.
    typedef struct packed {
        logic at_if;
        logic at_ex;
    } sup_hist_t;

    localparam sup_hist_t HIST_RESET = '{at_if: 1'b1, at_ex: 1'b1};
endpackage

// File: rtl/fu_supply_hist.sv
// Per-unit supply history: a fetch-stage and an execute-stage flop shifted
// on pipeline advance. Supply stays on unless both flops hold zero.
// Assumes adv marks a real stage advance of the data path.
module fu_supply_hist
    import fu_pwr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  logic sup_bit,
    output logic en
);
    sup_hist_t hist;

    // Shift the supply bit through the two stage flops on advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist <= HIST_RESET;
        end else if (adv) begin
            hist.at_if <= sup_bit;
            hist.at_ex <= hist.at_if;
        end
    end

    // Either flop set keeps the unit powered (early wake from the fetch flop).
    always_comb en = hist.at_if | hist.at_ex;
endmodule

// File: rtl/fu_iso_clamp.sv
// Output isolation for one unit: forces the result bus to zero while the
// supply is off and for one cycle after it returns.
// Assumes en comes from a register so it is glitch free.
module fu_iso_clamp #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [DATA_W-1:0] raw,
    output logic [DATA_W-1:0] out
);
    logic released;

    // Release one cycle after the supply has been seen on.
    always_ff @(posedge clk) begin
        if (!rst_n) released <= 1'b1;
        else        released <= en;
    end

    // Pass data only when powered and settled.
    always_comb out = (en && released) ? raw : '0;
endmodule

// File: rtl/fu_supply_ctrl.sv
// Supply gate controller for NUM_UNITS execution units. Each unit gets a
// history pipeline deciding its supply enable and a clamp on its result bus.
// Assumes result buses are packed unit-major, unit u at [u*DATA_W +: DATA_W].
module fu_supply_ctrl #(
    parameter int NUM_UNITS = 3,
    parameter int DATA_W    = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          adv,
    input  logic [NUM_UNITS-1:0]          sup_bit,
    input  logic [NUM_UNITS*DATA_W-1:0]   raw_in,
    output logic [NUM_UNITS-1:0]          sup_en,
    output logic [NUM_UNITS*DATA_W-1:0]   unit_out
);
    localparam int BUS_W = NUM_UNITS * DATA_W;

    logic [BUS_W-1:0] clamped;

    // One history pipeline and one clamp per unit.
    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        fu_supply_hist u_hist (
            .clk    (clk),
            .rst_n  (rst_n),
            .adv    (adv),
            .sup_bit(sup_bit[u]),
            .en     (sup_en[u])
        );

        fu_iso_clamp #(.DATA_W(DATA_W)) u_clamp (
            .clk  (clk),
            .rst_n(rst_n),
            .en   (sup_en[u]),
            .raw  (raw_in[u*DATA_W +: DATA_W]),
            .out  (clamped[u*DATA_W +: DATA_W])
        );
    end

    // Drive the clamped buses out.
    always_comb unit_out = clamped;
endmodule

// File: rtl/fu_supply_chk.sv
// Property checker for fu_supply_ctrl, attached through bind.
// Assumes the same parameters as the controller it watches.
module fu_supply_chk #(
    parameter int NUM_UNITS = 3,
    parameter int DATA_W    = 16
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        adv,
    input logic [NUM_UNITS-1:0]        sup_bit,
    input logic [NUM_UNITS*DATA_W-1:0] raw_in,
    input logic [NUM_UNITS-1:0]        sup_en,
    input logic [NUM_UNITS*DATA_W-1:0] unit_out
);
    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_chk
        // R3: a power-down follows only an advance that captured a zero
        assert_fall_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(sup_en[u]) |-> ($past(adv) && !$past(sup_bit[u])));
        // R4: no advance, no enable change
        assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(adv) |-> $stable(sup_en[u]));
        // R5: captured one wakes the unit immediately
        assert_early_wake_R5: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(adv) && $past(sup_bit[u])) |-> sup_en[u]);
        // R6: unpowered unit output is zero
        assert_off_clamp_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !sup_en[u] |-> (unit_out[u*DATA_W +: DATA_W] == '0));
        // R7: clamp held during the wake cycle
        assert_wake_clamp_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(sup_en[u]) |-> (unit_out[u*DATA_W +: DATA_W] == '0));
        // R9: settled unit passes data
        assert_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (sup_en[u] && $past(sup_en[u])) |->
                (unit_out[u*DATA_W +: DATA_W] == raw_in[u*DATA_W +: DATA_W]));
    end
endmodule

bind fu_supply_ctrl fu_supply_chk #(.NUM_UNITS(NUM_UNITS), .DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (adv),
    .sup_bit (sup_bit),
    .raw_in  (raw_in),
    .sup_en  (sup_en),
    .unit_out(unit_out)
);

// File: tb/fu_supply_ctrl_tb.sv
module fu_supply_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NU = 3;
    localparam int DW = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            adv = 1'b0;
    logic [NU-1:0]   sup_bit = '0;
    logic [NU*DW-1:0] raw_in = '0;
    logic [NU-1:0]   sup_en;
    logic [NU*DW-1:0] unit_out;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Behavioural model: per-unit queue of captured bits, last "on" flag.
    bit hq[NU][$];
    bit m_prev_on[NU];

    fu_supply_ctrl #(.NUM_UNITS(NU), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .adv(adv), .sup_bit(sup_bit),
        .raw_in(raw_in), .sup_en(sup_en), .unit_out(unit_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit m_on(int u);
        return hq[u][0] | hq[u][1];
    endfunction

    task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Apply inputs for one cycle, advance the model at the edge, compare after.
    task automatic step(bit a, logic [NU-1:0] b, logic [NU*DW-1:0] raw);
        adv = a; sup_bit = b; raw_in = raw;
        @(posedge clk);
        for (int u = 0; u < NU; u++) begin
            m_prev_on[u] = m_on(u);
            if (a) begin
                hq[u].push_front(b[u]);
                void'(hq[u].pop_back());
            end
        end
        @(negedge clk);
        for (int u = 0; u < NU; u++) begin
            logic [DW-1:0] e_out;
            e_out = (m_on(u) && m_prev_on[u]) ? raw[u*DW +: DW] : '0;
            chk(sup_en[u] == m_on(u), "R3 enable vs model", 64'(sup_en[u]), 64'(m_on(u)));
            chk(unit_out[u*DW +: DW] == e_out, "R6/R9 output vs model",
                64'(unit_out[u*DW +: DW]), 64'(e_out));
        end
    endtask

    localparam logic [NU*DW-1:0] RAW_A = 48'hC3C3_5A5A_1234;

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int u = 0; u < NU; u++) begin
            hq[u] = {1'b1, 1'b1};
            m_prev_on[u] = 1'b1;
        end
        raw_in = RAW_A;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk(sup_en == 3'b111, "R1 enables after reset", 64'(sup_en), 64'h7);
        chk(unit_out == RAW_A, "R1 outputs pass after reset", unit_out, RAW_A);

        // ALU: single zero -> stays on (R3)
        step(1, 3'b110, RAW_A);
        chk(sup_en[0] == 1'b1, "R3 single zero keeps supply", 64'(sup_en[0]), 64'h1);
        // R2: second advance shifts the 1 back; capture 1 again
        step(1, 3'b111, RAW_A);
        chk(sup_en == 3'b111, "R2 shift after one-stall", 64'(sup_en), 64'h7);
        // ALU run of zeros: falls after second zero (R3); LS stays on (R8)
        step(1, 3'b110, RAW_A);
        chk(sup_en[0] == 1'b1, "R3 first zero of run", 64'(sup_en[0]), 64'h1);
        step(1, 3'b110, RAW_A);
        chk(sup_en[0] == 1'b0, "R3 second zero powers off", 64'(sup_en[0]), 64'h0);
        chk(sup_en[1] == 1'b1, "R8 neighbour unaffected", 64'(sup_en[1]), 64'h1);
        chk(unit_out[DW-1:0] == '0, "R6 off output clamped", 64'(unit_out[DW-1:0]), 64'h0);
        // R4: no advance with a pending one
        step(0, 3'b111, RAW_A);
        step(0, 3'b111, RAW_A);
        chk(sup_en[0] == 1'b0, "R4 hold without advance", 64'(sup_en[0]), 64'h0);
        // R5: capture a one -> enable at once; R7 clamp still held
        step(1, 3'b111, RAW_A);
        chk(sup_en[0] == 1'b1, "R5 early wake", 64'(sup_en[0]), 64'h1);
        chk(unit_out[DW-1:0] == '0, "R7 clamp during wake cycle", 64'(unit_out[DW-1:0]), 64'h0);
        // R9: next cycle passes data
        step(0, 3'b000, RAW_A);
        chk(unit_out[DW-1:0] == RAW_A[DW-1:0], "R9 settled pass",
            64'(unit_out[DW-1:0]), 64'(RAW_A[DW-1:0]));

        // Random stream with stall runs compared every clock against the model.
        for (int i = 0; i < 600; i++) begin
            logic [NU-1:0] b;
            b = (($urandom % 4) == 0) ? NU'($urandom) : ((i / 8) % 2 == 0 ? 3'b000 : 3'b111);
            step(($urandom % 5) != 0, b, {$urandom, $urandom});
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule